// File: doc/BRIEF.md
# Reconfigurable Sliced Adder/Subtracter

A 32-bit integer adder/subtracter is split into four 8-bit slices. Each cycle, up to two instructions (A and B) each present two operand registers, a subtract control and a slice-allocation map. Every slice is idle, owned by A, or owned by B. A slice owned by the same instruction as the slice below it is chained: it takes carry and operation from below. Otherwise it is independent: it takes the operation from its own instruction, and its carry-in equals that instruction's subtract bit. The same hardware can therefore form one 32-bit sum or two narrower sums in the same cycle.

Input steering places the low bytes of each instruction's operands into the slices that instruction owns, starting at its lowest owned slice. Output steering collects the owned slice sums and shifts them back down to bit 0. It then sign-extends them to 32 bits and reports signed overflow from the instruction's topmost slice. Inputs are registered once per slice. An unallocated slice keeps its operand registers unchanged, so it does not toggle. The outputs are registered, which gives a latency of two clock edges. Which slices an instruction should get is decided elsewhere. This block only honours the maps it is given.

Top module: `sliced_addsub`

## Requirements
- R1: While reset is asserted, and at the first edges after its release, every output is zero.
- R2: Results for inputs presented before clock edge k appear after edge k+1. A valid output is 1 exactly when that instruction's effective map was non-zero.
- R3: With map 4'b1111 and sub bit 0, the result is op1+op2 modulo 2^32. With sub bit 1, the result is op1-op2 modulo 2^32.
- R4: Two instructions on disjoint slice groups are computed in the same cycle. No carry or borrow crosses from one group into the other.
- R5: An instruction owning n slices uses only bits [8n-1:0] of its operands, wherever its slices lie. Map bit i stands for slice i, which covers bits [8i+7:8i] of the internal datapath. Higher operand bits have no effect.
- R6: The n*8-bit result is right-aligned to bit 0. Bits above it are copies of bit 8n-1.
- R7: The overflow flag equals the two's-complement signed overflow of the n*8-bit add or subtract.
- R8: A slice set in both maps belongs to A. B uses only the slices in b_map & ~a_map.
- R9: An instruction with an empty effective map gives result 0, overflow 0 and valid 0.
- R10: In a chained group, a carry or borrow out of a lower slice enters the next slice up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_op1 | input | 32 | Instruction A first operand, right-aligned |
| a_op2 | input | 32 | Instruction A second operand, right-aligned |
| a_map | input | 4 | Instruction A slice map, bit i = slice i, contiguous |
| a_sub | input | 1 | Instruction A operation: 0 add, 1 subtract |
| b_op1 | input | 32 | Instruction B first operand, right-aligned |
| b_op2 | input | 32 | Instruction B second operand, right-aligned |
| b_map | input | 4 | Instruction B slice map, contiguous after A's slices are removed |
| b_sub | input | 1 | Instruction B operation: 0 add, 1 subtract |
| a_res | output | 32 | Instruction A sign-extended result |
| a_ovf | output | 1 | Instruction A signed overflow |
| a_vld | output | 1 | Instruction A result valid |
| b_res | output | 32 | Instruction B sign-extended result |
| b_ovf | output | 1 | Instruction B signed overflow |
| b_vld | output | 1 | Instruction B result valid |

## Verification
The bench places a 16-bit group directly below another group with a carry leaving the lower one. A design that leaked that carry across the boundary would corrupt the upper instruction's sum. Single slices placed high in the datapath, with junk in the upper operand bytes, catch a design that steers the wrong byte or fails to shift the result back to bit 0. Positive-to-negative wraps at 8, 16, 24 and 32 bits catch a missing sign extension and an overflow flag taken from the wrong slice. Overlapping maps, empty maps and multi-slice borrows catch wrong ownership priority, stale results and a broken chained borrow.

// File: rtl/sas_pkg.sv
package sas_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_A    = 2'd1,
        OWN_B    = 2'd2
    } owner_e;

    function automatic int low_index(input logic [15:0] m);
        int r;
        r = 0;
        for (int i = 15; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

    function automatic int pop_count(input logic [15:0] m);
        int r;
        r = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) r = r + 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/sas_steer_in.sv
module sas_steer_in
    import sas_pkg::*;
#(
    parameter  int SW = 8,
    parameter  int NS = 4,
    localparam int DW = SW * NS,
    localparam int IW = $clog2(NS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a_op1,
    input  logic [DW-1:0] a_op2,
    input  logic [NS-1:0] a_map,
    input  logic          a_sub,
    input  logic [DW-1:0] b_op1,
    input  logic [DW-1:0] b_op2,
    input  logic [NS-1:0] b_map,
    input  logic          b_sub,
    output logic [SW-1:0] x_q     [NS],
    output logic [SW-1:0] y_q     [NS],
    output owner_e        own_q   [NS],
    output logic          sub_q   [NS],
    output logic          chain_q [NS],
    output logic [IW-1:0] a_lo_q,
    output logic [IW-1:0] a_cnt_q,
    output logic [IW-1:0] b_lo_q,
    output logic [IW-1:0] b_cnt_q
);

    logic [NS-1:0] b_eff;
    int            a_lo, a_cnt, b_lo, b_cnt;
    logic [DW-1:0] a_x_sh, a_y_sh, b_x_sh, b_y_sh;
    owner_e        own_d [NS];

    assign b_eff = b_map & ~a_map;

    always_comb begin
        a_lo   = low_index(16'(a_map));
        a_cnt  = pop_count(16'(a_map));
        b_lo   = low_index(16'(b_eff));
        b_cnt  = pop_count(16'(b_eff));
        a_x_sh = a_op1 << (a_lo * SW);
        a_y_sh = a_op2 << (a_lo * SW);
        b_x_sh = b_op1 << (b_lo * SW);
        b_y_sh = b_op2 << (b_lo * SW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_lo_q  <= '0;
            a_cnt_q <= '0;
            b_lo_q  <= '0;
            b_cnt_q <= '0;
        end else begin
            a_lo_q  <= IW'(a_lo);
            a_cnt_q <= IW'(a_cnt);
            b_lo_q  <= IW'(b_lo);
            b_cnt_q <= IW'(b_cnt);
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_slice
        logic [SW-1:0] xd, yd;
        logic          sd;
        logic          ch_d;

        assign own_d[s] = a_map[s] ? OWN_A : (b_eff[s] ? OWN_B : OWN_NONE);

        if (s == 0) begin : g_base
            assign ch_d = 1'b0;
        end else begin : g_upper
            assign ch_d = (own_d[s] != OWN_NONE) && (own_d[s] == own_d[s-1]);
        end

        always_comb begin
            unique case (own_d[s])
                OWN_A: begin
                    xd = a_x_sh[s*SW +: SW];
                    yd = a_y_sh[s*SW +: SW];
                    sd = a_sub;
                end
                OWN_B: begin
                    xd = b_x_sh[s*SW +: SW];
                    yd = b_y_sh[s*SW +: SW];
                    sd = b_sub;
                end
                default: begin
                    xd = '0;
                    yd = '0;
                    sd = 1'b0;
                end
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                own_q[s]   <= OWN_NONE;
                x_q[s]     <= '0;
                y_q[s]     <= '0;
                sub_q[s]   <= 1'b0;
                chain_q[s] <= 1'b0;
            end else begin
                own_q[s]   <= own_d[s];
                sub_q[s]   <= sd;
                chain_q[s] <= ch_d;
                if (own_d[s] != OWN_NONE) begin
                    x_q[s] <= xd;
                    y_q[s] <= yd;
                end
            end
        end

        // R8
        a_wins_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
            a_map[s] |=> (own_q[s] == OWN_A));
    end

endmodule

// File: rtl/sas_slice.sv
module sas_slice #(
    parameter int SW = 8
) (
    input  logic [SW-1:0] x,
    input  logic [SW-1:0] y,
    input  logic          sub_own,
    input  logic          chain,
    input  logic          sub_dn,
    input  logic          c_dn,
    output logic [SW-1:0] sum,
    output logic          c_up,
    output logic          sub_up,
    output logic          v
);

    logic          sub_eff, cin;
    logic [SW-1:0] yi;
    logic [SW-1:0] lo_sum;
    logic [1:0]    hi_sum;

    always_comb begin
        sub_eff = chain ? sub_dn : sub_own;
        cin     = chain ? c_dn : sub_own;
        yi      = y ^ {SW{sub_eff}};
        lo_sum  = {1'b0, x[SW-2:0]} + {1'b0, yi[SW-2:0]} + {{(SW-1){1'b0}}, cin};
        hi_sum  = {1'b0, x[SW-1]} + {1'b0, yi[SW-1]} + {1'b0, lo_sum[SW-1]};
        sum     = {hi_sum[0], lo_sum[SW-2:0]};
        c_up    = hi_sum[1];
        sub_up  = sub_eff;
        v       = hi_sum[1] ^ lo_sum[SW-1];
    end

endmodule

// File: rtl/sas_steer_out.sv
module sas_steer_out
    import sas_pkg::*;
#(
    parameter  int     SW  = 8,
    parameter  int     NS  = 4,
    parameter  owner_e WHO = OWN_A,
    localparam int     DW  = SW * NS,
    localparam int     IW  = $clog2(NS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sum [NS],
    input  logic          v   [NS],
    input  owner_e        own [NS],
    input  logic [IW-1:0] lo,
    input  logic [IW-1:0] cnt,
    output logic [DW-1:0] res,
    output logic          ovf,
    output logic          vld
);

    logic [DW-1:0] grp, sh;
    logic          sgn;
    int            top;

    always_comb begin
        grp = '0;
        for (int s = 0; s < NS; s++) begin
            if (own[s] == WHO) grp[s*SW +: SW] = sum[s];
        end
        sh  = grp >> (int'(lo) * SW);
        sgn = 1'b0;
        top = 0;
        ovf = 1'b0;
        vld = (cnt != '0);
        if (cnt != '0) begin
            sgn = sh[int'(cnt) * SW - 1];
            top = int'(lo) + int'(cnt) - 1;
            ovf = v[top];
        end
        for (int j = 0; j < NS; j++) begin
            res[j*SW +: SW] = (j < int'(cnt)) ? sh[j*SW +: SW] : {SW{sgn}};
        end
    end

    // R6
    one_slice_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == IW'(1)) |-> (res[DW-1:SW-1] == {(DW-SW+1){res[SW-1]}}));

endmodule

// File: rtl/sliced_addsub.sv
module sliced_addsub
    import sas_pkg::*;
#(
    parameter  int SLICE_W = 8,
    parameter  int N_SLICE = 4,
    localparam int DW      = SLICE_W * N_SLICE,
    localparam int IW      = $clog2(N_SLICE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DW-1:0]      a_op1,
    input  logic [DW-1:0]      a_op2,
    input  logic [N_SLICE-1:0] a_map,
    input  logic               a_sub,
    input  logic [DW-1:0]      b_op1,
    input  logic [DW-1:0]      b_op2,
    input  logic [N_SLICE-1:0] b_map,
    input  logic               b_sub,
    output logic [DW-1:0]      a_res,
    output logic               a_ovf,
    output logic               a_vld,
    output logic [DW-1:0]      b_res,
    output logic               b_ovf,
    output logic               b_vld
);

    logic [SLICE_W-1:0] x_q     [N_SLICE];
    logic [SLICE_W-1:0] y_q     [N_SLICE];
    owner_e             own_q   [N_SLICE];
    logic               sub_q   [N_SLICE];
    logic               chain_q [N_SLICE];
    logic [IW-1:0]      a_lo_q, a_cnt_q, b_lo_q, b_cnt_q;

    logic [SLICE_W-1:0] sl_sum [N_SLICE];
    logic               sl_cup [N_SLICE];
    logic               sl_sup [N_SLICE];
    logic               sl_v   [N_SLICE];

    logic [DW-1:0]      ra_d, rb_d;
    logic               oa_d, ob_d, va_d, vb_d;

    sas_steer_in #(.SW(SLICE_W), .NS(N_SLICE)) u_steer_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_op1   (a_op1),
        .a_op2   (a_op2),
        .a_map   (a_map),
        .a_sub   (a_sub),
        .b_op1   (b_op1),
        .b_op2   (b_op2),
        .b_map   (b_map),
        .b_sub   (b_sub),
        .x_q     (x_q),
        .y_q     (y_q),
        .own_q   (own_q),
        .sub_q   (sub_q),
        .chain_q (chain_q),
        .a_lo_q  (a_lo_q),
        .a_cnt_q (a_cnt_q),
        .b_lo_q  (b_lo_q),
        .b_cnt_q (b_cnt_q)
    );

    for (genvar s = 0; s < N_SLICE; s++) begin : g_alu
        logic sub_dn, c_dn;
        if (s == 0) begin : g_first
            assign sub_dn = 1'b0;
            assign c_dn   = 1'b0;
        end else begin : g_next
            assign sub_dn = sl_sup[s-1];
            assign c_dn   = sl_cup[s-1];
        end

        sas_slice #(.SW(SLICE_W)) u_slice (
            .x       (x_q[s]),
            .y       (y_q[s]),
            .sub_own (sub_q[s]),
            .chain   (chain_q[s]),
            .sub_dn  (sub_dn),
            .c_dn    (c_dn),
            .sum     (sl_sum[s]),
            .c_up    (sl_cup[s]),
            .sub_up  (sl_sup[s]),
            .v       (sl_v[s])
        );
    end

    sas_steer_out #(.SW(SLICE_W), .NS(N_SLICE), .WHO(OWN_A)) u_out_a (
        .clk   (clk),
        .rst_n (rst_n),
        .sum   (sl_sum),
        .v     (sl_v),
        .own   (own_q),
        .lo    (a_lo_q),
        .cnt   (a_cnt_q),
        .res   (ra_d),
        .ovf   (oa_d),
        .vld   (va_d)
    );

    sas_steer_out #(.SW(SLICE_W), .NS(N_SLICE), .WHO(OWN_B)) u_out_b (
        .clk   (clk),
        .rst_n (rst_n),
        .sum   (sl_sum),
        .v     (sl_v),
        .own   (own_q),
        .lo    (b_lo_q),
        .cnt   (b_cnt_q),
        .res   (rb_d),
        .ovf   (ob_d),
        .vld   (vb_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_res <= '0;
            a_ovf <= 1'b0;
            a_vld <= 1'b0;
            b_res <= '0;
            b_ovf <= 1'b0;
            b_vld <= 1'b0;
        end else begin
            a_res <= ra_d;
            a_ovf <= oa_d;
            a_vld <= va_d;
            b_res <= rb_d;
            b_ovf <= ob_d;
            b_vld <= vb_d;
        end
    end

    logic [1:0] up_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              up_cnt <= 2'd0;
        else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
    end

    // R9
    a_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_vld |-> (a_res == '0 && !a_ovf));

    // R9
    b_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_vld |-> (b_res == '0 && !b_ovf));

    // R2
    a_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd2) |-> (a_vld == $past(|a_map, 2)));

    // R2
    b_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd2) |-> (b_vld == $past(|(b_map & ~a_map), 2)));

endmodule

// File: tb/sliced_addsub_tb.sv
module sliced_addsub_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_op1 = '0, a_op2 = '0, b_op1 = '0, b_op2 = '0;
    logic [3:0]  a_map = '0, b_map = '0;
    logic        a_sub = 1'b0, b_sub = 1'b0;
    logic [31:0] a_res, b_res;
    logic        a_ovf, a_vld, b_ovf, b_vld;

    int          n_vec  = 0;
    int          n_fail = 0;
    logic [33:0] prev_a = '0, prev_b = '0;
    string       prev_rq = "R1";

    always #5 clk = ~clk;

    sliced_addsub u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .a_op1 (a_op1),
        .a_op2 (a_op2),
        .a_map (a_map),
        .a_sub (a_sub),
        .b_op1 (b_op1),
        .b_op2 (b_op2),
        .b_map (b_map),
        .b_sub (b_sub),
        .a_res (a_res),
        .a_ovf (a_ovf),
        .a_vld (a_vld),
        .b_res (b_res),
        .b_ovf (b_ovf),
        .b_vld (b_vld)
    );

    // Behavioural model: {vld, ovf, res}
    function automatic logic [33:0] model(input logic [31:0] o1, input logic [31:0] o2,
                                          input logic [3:0] m, input logic s);
        int          n, w;
        logic [63:0] mask, a, b, r;
        logic        sa, sb, sr, ov;
        logic [31:0] res;
        n = 0;
        for (int i = 0; i < 4; i++) if (m[i]) n = n + 1;
        if (n == 0) return '0;
        w    = n * 8;
        mask = (64'd1 << w) - 64'd1;
        a    = {32'd0, o1} & mask;
        b    = {32'd0, o2} & mask;
        r    = (s ? (a - b) : (a + b)) & mask;
        sa   = a[w-1];
        sb   = b[w-1];
        sr   = r[w-1];
        ov   = s ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
        res  = sr ? 32'(r | ~mask) : 32'(r);
        return {1'b1, ov, res};
    endfunction

    task automatic compare(input string rq, input string port,
                           input logic [33:0] act, input logic [33:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s port %s: got vld=%0b ovf=%0b res=%h, want vld=%0b ovf=%0b res=%h",
                     rq, port, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic apply(input logic [31:0] x1, input logic [31:0] x2, input logic [3:0] xm,
                         input logic xs, input logic [31:0] y1, input logic [31:0] y2,
                         input logic [3:0] ym, input logic ys, input string rq);
        logic [33:0] ea, eb;
        a_op1 = x1; a_op2 = x2; a_map = xm; a_sub = xs;
        b_op1 = y1; b_op2 = y2; b_map = ym; b_sub = ys;
        ea = model(x1, x2, xm, xs);
        eb = model(y1, y2, ym & ~xm, ys);
        @(negedge clk);
        compare(prev_rq, "A", {a_vld, a_ovf, a_res}, prev_a);
        compare(prev_rq, "B", {b_vld, b_ovf, b_res}, prev_b);
        prev_a  = ea;
        prev_b  = eb;
        prev_rq = rq;
    endtask

    task automatic idle(input string rq);
        apply('0, '0, 4'b0000, 1'b0, '0, '0, 4'b0000, 1'b0, rq);
    endtask

    initial begin : watchdog
        #100us;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout, want finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stim
        // R1: reset holds outputs at zero even with live inputs
        a_op1 = 32'hFFFF_FFFF; a_op2 = 32'h1; a_map = 4'hF; a_sub = 1'b0;
        b_op1 = 32'h7F;        b_op2 = 32'h1; b_map = 4'hF; b_sub = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1", "A", {a_vld, a_ovf, a_res}, '0);
        compare("R1", "B", {b_vld, b_ovf, b_res}, '0);
        rst_n = 1'b1;
        idle("R1");
        idle("R2");

        // R3: full-width add and subtract
        apply(32'h1234_5678, 32'h1111_1111, 4'hF, 1'b0, '0, '0, 4'h0, 1'b0, "R3");
        apply(32'h1000_0000, 32'h0000_0001, 4'hF, 1'b1, '0, '0, 4'h0, 1'b0, "R3");
        apply(32'hFFFF_FFFF, 32'h0000_0001, 4'hF, 1'b0, '0, '0, 4'h0, 1'b0, "R3");
        // R7: 32-bit overflow on add and subtract
        apply(32'h7FFF_FFFF, 32'h0000_0001, 4'hF, 1'b0, '0, '0, 4'h0, 1'b0, "R7");
        apply(32'h8000_0000, 32'h0000_0001, 4'hF, 1'b1, '0, '0, 4'h0, 1'b0, "R7");

        // R4: carry out of A's group must not reach B above it
        apply(32'h0000_FFFF, 32'h0000_0001, 4'b0011, 1'b0,
              32'h0000_0102, 32'h0000_0304, 4'b1100, 1'b0, "R4");
        apply(32'h0000_00FF, 32'h0000_0001, 4'b0011, 1'b0,
              32'h0000_7FFF, 32'h0000_0001, 4'b1100, 1'b0, "R4");
        // R4: B low, A high, back to back
        apply(32'h0000_0005, 32'h0000_0009, 4'b1000, 1'b1,
              32'h00FF_FFFF, 32'h0000_0001, 4'b0111, 1'b0, "R4");

        // R5: single high slices with junk in upper operand bytes
        apply(32'hABCD_EF05, 32'h1234_5603, 4'b0100, 1'b0,
              32'hDEAD_BE7F, 32'hCAFE_F001, 4'b1000, 1'b0, "R5");
        // R6: 24-bit positive wrap and 8-bit borrow to all ones
        apply(32'h007F_FFFF, 32'h0000_0001, 4'b1110, 1'b0,
              32'h0000_0000, 32'h0000_0001, 4'b0001, 1'b1, "R6");
        // R6: 16-bit group high in datapath, negative result
        apply(32'h5555_0003, 32'h9999_0005, 4'b1100, 1'b1,
              32'h0000_0040, 32'h0000_0040, 4'b0010, 1'b0, "R6");

        // R8: overlap goes to A, B keeps slice 2 only
        apply(32'h0000_1234, 32'h0000_0001, 4'b0011, 1'b0,
              32'h0000_0080, 32'h0000_0001, 4'b0110, 1'b1, "R8");
        // R9: empty A map with junk, B full
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0000, 1'b1,
              32'h0000_0010, 32'h0000_0020, 4'b1111, 1'b1, "R9");
        // R9: B fully shadowed by A
        apply(32'h0000_0001, 32'h0000_0001, 4'b0011, 1'b0,
              32'h0000_0077, 32'h0000_0011, 4'b0010, 1'b0, "R9");

        // R10: borrows through chained slices
        apply(32'h0000_0100, 32'h0000_0001, 4'b0011, 1'b1,
              32'h0000_0000, 32'h0000_0001, 4'b1100, 1'b1, "R10");
        apply(32'h0100_0000, 32'h0000_0001, 4'b1111, 1'b1, '0, '0, 4'h0, 1'b0, "R10");

        idle("R2");

        // R4: randomized disjoint contiguous layouts
        for (int k = 0; k < 80; k++) begin
            int          lo1, n1, st, n2;
            logic [3:0]  m1, m2;
            lo1 = int'($urandom % 4);
            n1  = int'($urandom % (5 - lo1));
            st  = lo1 + n1;
            n2  = (st < 4) ? int'($urandom % (5 - st)) : 0;
            m1  = 4'((5'd1 << n1) - 5'd1) << lo1;
            m2  = 4'(((5'd1 << n2) - 5'd1) << st);
            if ($urandom % 2 == 0)
                apply($urandom, $urandom, m1, 1'($urandom), $urandom, $urandom, m2, 1'($urandom), "R4");
            else
                apply($urandom, $urandom, m2, 1'($urandom), $urandom, $urandom, m1, 1'($urandom), "R4");
        end

        idle("R2");
        idle("R2");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule